// File: doc/BRIEF.md
# Single-Step Bus Trace Controller

This block sits between a debug command channel and an attached processor. It generates the processor's clock one phase at a time, drives its reset, and holds its remaining control inputs (ready, interrupt request, non-maskable interrupt, set-overflow, bus enable) at their inactive high level. After reset it runs in step mode. In this mode it completes one bus cycle, emits a text record of what it saw on the bus, and then stops the clock until a command byte arrives.

Command bytes arrive over a valid/ready channel. Four bytes are recognised:
- `s` steps one bus cycle.
- `c` switches to free running.
- `b` returns to step mode.
- `r` repeats the reset sequence.

Each command acts only in the mode where it makes sense. In free-running mode, the controller looks for one command byte after every bus cycle and emits no records. Trace characters leave one byte at a time over a valid/ready stream, so a slow serial transmitter can pace them.

Top module: `bt_step_trace`

## Requirements
- R1: Reset sequence. After `rst_n` is released, and after each accepted `r`, `cpu_rst_n` is low for exactly 2 rising edges of `cpu_clk`. It is then high for 7 rising edges before the first bus cycle starts. That bus cycle is the next rising edge.
- R2: `cpu_rdy`, `cpu_irq_n`, `cpu_nmi_n`, `cpu_so_n` and `cpu_be` are high from reset onward.
- R3: The controller starts in step mode. After the reset sequence it runs one bus cycle, emits its record and then holds `cpu_clk` low with `cmd_ready` high.
- R4: In step mode, `s` (0x73) produces exactly one further `cpu_clk` rising edge and then exactly one record.
- R5: In step mode, `c` (0x63) starts free running. `cpu_clk` keeps pulsing and no record is emitted.
- R6: In free-running mode, `b` (0x62) returns to step mode. The next bus cycle is traced and the clock then halts.
- R7: `b` in step mode, and `s` or `c` in free-running mode, are consumed but leave the mode and clocking unchanged.
- R8: Any byte other than `s`, `c`, `b` or `r` is consumed and discarded, with no effect in either mode.
- R9: `r` (0x72) runs the R1 sequence in either mode and keeps the current mode.
- R10: A record is 14 characters, in this order:
  - `r` if `cpu_rw`=1, otherwise `W`;
  - `S` if `cpu_sync`=1, otherwise `-`;
  - `M` if `cpu_mlock_n`=0, otherwise `-`;
  - `V` if `cpu_vpull_n`=0, otherwise `-`;
  - a space;
  - the address as 4 lowercase hex digits, most significant digit first;
  - a space;
  - the data as 2 lowercase hex digits;
  - 0x0D, then 0x0A.

  The fields are the input values present at the end of the clock-high phase.
- R11: A trace character advances only when `trace_valid` and `trace_ready` are both high. While it is stalled, `trace_char` and `trace_valid` stay unchanged.
- R12: In free-running mode, `cmd_ready` is high for exactly one cycle after each bus cycle. It is never high together with `trace_valid`, nor while `cpu_rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_data | input | 8 | Command byte |
| cmd_ready | output | 1 | Controller takes a command this cycle |
| cpu_addr | input | 16 | Processor address bus |
| cpu_data | input | 8 | Processor data bus as observed |
| cpu_rw | input | 1 | Processor read (1) / write (0) |
| cpu_sync | input | 1 | Opcode fetch marker |
| cpu_mlock_n | input | 1 | Memory lock, active low |
| cpu_vpull_n | input | 1 | Vector pull, active low |
| cpu_clk | output | 1 | Processor clock |
| cpu_rst_n | output | 1 | Processor reset, active low |
| cpu_rdy | output | 1 | Processor ready, held high |
| cpu_irq_n | output | 1 | Interrupt request, held high |
| cpu_nmi_n | output | 1 | Non-maskable interrupt, held high |
| cpu_so_n | output | 1 | Set overflow, held high |
| cpu_be | output | 1 | Bus enable, held high |
| trace_valid | output | 1 | Trace character present |
| trace_char | output | 8 | Trace character |
| trace_ready | input | 1 | Consumer takes the trace character |

## Verification
The hardest situation to reach is a command arriving in free-running mode. There, `cmd_ready` opens for only one cycle in every three, so the stimulus holds the byte until the handshake completes. The bench then judges the effect from the clock pulses and the absence of records. It counts `cpu_clk` edges both during reset and overall, so that `r` given in each mode can be confirmed to produce exactly 2 + 7 edges and to keep the mode. Random trace back-pressure and random bus values at every rising edge test the record contents and the stall behaviour together.

// File: rtl/bt_pkg.sv
// Shared definitions for the single-step bus trace controller.
// Assumes byte-wide command codes in ASCII.
package bt_pkg;

    typedef enum logic [3:0] {
        ST_START,   // reset held, clock low
        ST_RLO_H,   // reset low, clock high phase
        ST_RLO_L,   // reset low, clock low phase
        ST_RHI_H,   // reset released, clock high phase
        ST_RHI_L,   // reset released, clock low phase
        ST_BUS_H,   // bus cycle, clock high phase
        ST_BUS_L,   // bus cycle, clock low phase
        ST_CHECK,   // after a bus cycle: poll command or trace
        ST_EMIT,    // sending a trace record
        ST_WAIT     // halted in step mode
    } seq_state_t;

    localparam logic [7:0] CMD_STEP  = 8'h73;
    localparam logic [7:0] CMD_CONT  = 8'h63;
    localparam logic [7:0] CMD_BREAK = 8'h62;
    localparam logic [7:0] CMD_RESET = 8'h72;

    localparam logic [7:0] CH_SPACE = 8'h20;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;
    localparam logic [7:0] CH_DASH  = 8'h2D;

    // Lowercase hex digit for a nibble.
    function automatic logic [7:0] hex_char(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h57 + {4'h0, n});
    endfunction

endpackage

// File: rtl/bt_seq_ctrl.sv
// Sequencer: produces processor clock phases, runs the reset sequence,
// keeps the step/free mode, and decodes command bytes.
// Assumes one system clock per processor clock phase.
module bt_seq_ctrl
    import bt_pkg::*;
#(
    parameter int RST_LO_CYC = 2,
    parameter int RST_HI_CYC = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_data,
    output logic       cmd_ready,
    input  logic       rec_last,
    output logic       cpu_clk,
    output logic       cpu_rst_n,
    output logic       cap_en,
    output logic       emit_on,
    output logic       free_mode
);

    localparam int CNT_MAX = (RST_LO_CYC > RST_HI_CYC) ? RST_LO_CYC : RST_HI_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(RST_LO_CYC - 1);
    localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(RST_HI_CYC - 1);

    seq_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             free_nx;

    // Decode outputs from the current state.
    always_comb begin
        cpu_clk   = (state == ST_RLO_H) || (state == ST_RHI_H) || (state == ST_BUS_H);
        cpu_rst_n = !((state == ST_START) || (state == ST_RLO_H) || (state == ST_RLO_L));
        cap_en    = (state == ST_BUS_H);
        emit_on   = (state == ST_EMIT);
        cmd_ready = (state == ST_WAIT) || ((state == ST_CHECK) && free_mode);
    end

    // Next-state, counter and mode logic.
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        free_nx  = free_mode;
        unique case (state)
            ST_START: state_nx = ST_RLO_H;
            ST_RLO_H: state_nx = ST_RLO_L;
            ST_RLO_L: begin
                if (cnt == LO_LAST) begin
                    cnt_nx   = '0;
                    state_nx = ST_RHI_H;
                end else begin
                    cnt_nx   = cnt + 1'b1;
                    state_nx = ST_RLO_H;
                end
            end
            ST_RHI_H: state_nx = ST_RHI_L;
            ST_RHI_L: begin
                if (cnt == HI_LAST) begin
                    cnt_nx   = '0;
                    state_nx = ST_BUS_H;
                end else begin
                    cnt_nx   = cnt + 1'b1;
                    state_nx = ST_RHI_H;
                end
            end
            ST_BUS_H: state_nx = ST_BUS_L;
            ST_BUS_L: state_nx = ST_CHECK;
            ST_CHECK: begin
                if (!free_mode) begin
                    state_nx = ST_EMIT;
                end else begin
                    state_nx = ST_BUS_H;
                    if (cmd_valid) begin
                        if (cmd_data == CMD_BREAK) free_nx = 1'b0;
                        else if (cmd_data == CMD_RESET) state_nx = ST_RLO_H;
                    end
                end
            end
            ST_EMIT: if (rec_last) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (cmd_valid) begin
                    if (cmd_data == CMD_STEP) begin
                        state_nx = ST_BUS_H;
                    end else if (cmd_data == CMD_CONT) begin
                        free_nx  = 1'b1;
                        state_nx = ST_BUS_H;
                    end else if (cmd_data == CMD_RESET) begin
                        state_nx = ST_RLO_H;
                    end
                end
            end
            default: state_nx = ST_START;
        endcase
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_START;
            cnt       <= '0;
            free_mode <= 1'b0;
        end else begin
            state     <= state_nx;
            cnt       <= cnt_nx;
            free_mode <= free_nx;
        end
    end

endmodule

// File: rtl/bt_trace_fmt.sv
// Combinational formatter: maps a character index in a trace record
// to its character. Assumes address and data widths are multiples of 4.
module bt_trace_fmt
    import bt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int AHEX  = ADDR_W / 4,
    localparam int DHEX  = DATA_W / 4,
    localparam int REC_LEN = 4 + 1 + AHEX + 1 + DHEX + 2,
    localparam int IDX_W = $clog2(REC_LEN)
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              f_rw,
    input  logic              f_sync,
    input  logic              f_mlock_n,
    input  logic              f_vpull_n,
    input  logic [ADDR_W-1:0] f_addr,
    input  logic [DATA_W-1:0] f_data,
    output logic [7:0]        ch
);

    localparam int A0 = 5;
    localparam int D0 = A0 + AHEX + 1;
    localparam int E0 = D0 + DHEX;

    logic [ADDR_W-1:0] a_sh;
    logic [DATA_W-1:0] d_sh;
    int                i;

    // Select the character for the current index.
    always_comb begin
        i    = int'(idx);
        a_sh = '0;
        d_sh = '0;
        ch   = CH_SPACE;
        if (i == 0) begin
            ch = f_rw ? 8'h72 : 8'h57;
        end else if (i == 1) begin
            ch = f_sync ? 8'h53 : CH_DASH;
        end else if (i == 2) begin
            ch = f_mlock_n ? CH_DASH : 8'h4D;
        end else if (i == 3) begin
            ch = f_vpull_n ? CH_DASH : 8'h56;
        end else if (i >= A0 && i < A0 + AHEX) begin
            a_sh = f_addr >> (4 * (AHEX - 1 - (i - A0)));
            ch   = hex_char(a_sh[3:0]);
        end else if (i >= D0 && i < E0) begin
            d_sh = f_data >> (4 * (DHEX - 1 - (i - D0)));
            ch   = hex_char(d_sh[3:0]);
        end else if (i == E0) begin
            ch = CH_CR;
        end else if (i == E0 + 1) begin
            ch = CH_LF;
        end
    end

endmodule

// File: rtl/bt_trace_tx.sv
// Trace emitter: captures the bus fields at the end of the clock-high
// phase and streams the formatted record over a valid/ready handshake.
// Assumes the capture strobe never coincides with an active record.
module bt_trace_tx #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int REC_LEN = 4 + 1 + ADDR_W / 4 + 1 + DATA_W / 4 + 2,
    localparam int IDX_W = $clog2(REC_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              emit_on,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_rw,
    input  logic              cpu_sync,
    input  logic              cpu_mlock_n,
    input  logic              cpu_vpull_n,
    input  logic              trace_ready,
    output logic              trace_valid,
    output logic [7:0]        trace_char,
    output logic              rec_last
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(REC_LEN - 1);

    logic [IDX_W-1:0]  idx;
    logic              r_rw, r_sync, r_ml_n, r_vp_n;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_data;
    logic              fire;

    assign trace_valid = emit_on;
    assign fire        = emit_on && trace_ready;
    assign rec_last    = fire && (idx == IDX_LAST);

    // Capture the bus fields on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_rw   <= 1'b1;
            r_sync <= 1'b0;
            r_ml_n <= 1'b1;
            r_vp_n <= 1'b1;
            r_addr <= '0;
            r_data <= '0;
        end else if (cap_en) begin
            r_rw   <= cpu_rw;
            r_sync <= cpu_sync;
            r_ml_n <= cpu_mlock_n;
            r_vp_n <= cpu_vpull_n;
            r_addr <= cpu_addr;
            r_data <= cpu_data;
        end
    end

    // Advance the character index on each accepted character.
    always_ff @(posedge clk) begin
        if (!rst_n) idx <= '0;
        else if (rec_last) idx <= '0;
        else if (fire) idx <= idx + 1'b1;
    end

    bt_trace_fmt #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fmt (
        .idx       (idx),
        .f_rw      (r_rw),
        .f_sync    (r_sync),
        .f_mlock_n (r_ml_n),
        .f_vpull_n (r_vp_n),
        .f_addr    (r_addr),
        .f_data    (r_data),
        .ch        (trace_char)
    );

endmodule

// File: rtl/bt_step_trace.sv
// Top: single-step bus trace controller. Joins the sequencer and the
// trace emitter and holds the unused processor controls inactive.
// Assumes the processor samples its inputs on cpu_clk edges only.
module bt_step_trace #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int RST_LO_CYC = 2,
    parameter int RST_HI_CYC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_data,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_rw,
    input  logic              cpu_sync,
    input  logic              cpu_mlock_n,
    input  logic              cpu_vpull_n,
    output logic              cpu_clk,
    output logic              cpu_rst_n,
    output logic              cpu_rdy,
    output logic              cpu_irq_n,
    output logic              cpu_nmi_n,
    output logic              cpu_so_n,
    output logic              cpu_be,
    output logic              trace_valid,
    output logic [7:0]        trace_char,
    input  logic              trace_ready
);

    logic cap_en, emit_on, rec_last, free_mode;

    // Unused processor controls stay inactive at all times.
    assign cpu_rdy   = 1'b1;
    assign cpu_irq_n = 1'b1;
    assign cpu_nmi_n = 1'b1;
    assign cpu_so_n  = 1'b1;
    assign cpu_be    = 1'b1;

    bt_seq_ctrl #(
        .RST_LO_CYC (RST_LO_CYC),
        .RST_HI_CYC (RST_HI_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .cmd_ready (cmd_ready),
        .rec_last  (rec_last),
        .cpu_clk   (cpu_clk),
        .cpu_rst_n (cpu_rst_n),
        .cap_en    (cap_en),
        .emit_on   (emit_on),
        .free_mode (free_mode)
    );

    bt_trace_tx #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_en      (cap_en),
        .emit_on     (emit_on),
        .cpu_addr    (cpu_addr),
        .cpu_data    (cpu_data),
        .cpu_rw      (cpu_rw),
        .cpu_sync    (cpu_sync),
        .cpu_mlock_n (cpu_mlock_n),
        .cpu_vpull_n (cpu_vpull_n),
        .trace_ready (trace_ready),
        .trace_valid (trace_valid),
        .trace_char  (trace_char),
        .rec_last    (rec_last)
    );

endmodule

// File: rtl/bt_step_trace_chk.sv
// Checker for bt_step_trace: protocol and mode properties.
module bt_step_trace_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_ready,
    input logic       cpu_clk,
    input logic       cpu_rst_n,
    input logic       trace_valid,
    input logic [7:0] trace_char,
    input logic       trace_ready,
    input logic       free_mode
);

    // R11: a stalled character holds.
    a_r11_hold_char: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_valid && !trace_ready) |=> (trace_valid && $stable(trace_char)));

    // R5: no record while running freely.
    a_r5_no_trace_free: assert property (@(posedge clk) disable iff (!rst_n)
        free_mode |-> !trace_valid);

    // R1: nothing is offered or taken during processor reset.
    a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rst_n |-> (!trace_valid && !cmd_ready));

    // R3: clock is parked low whenever a command can be taken.
    a_r3_clk_parked: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!cpu_clk && cpu_rst_n));

    // R12: command acceptance and trace output never overlap.
    a_r12_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ready && trace_valid));

endmodule

bind bt_step_trace bt_step_trace_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ready   (cmd_ready),
    .cpu_clk     (cpu_clk),
    .cpu_rst_n   (cpu_rst_n),
    .trace_valid (trace_valid),
    .trace_char  (trace_char),
    .trace_ready (trace_ready),
    .free_mode   (free_mode)
);

// File: tb/bt_step_trace_bench.sv
module bt_step_trace_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_data = 8'h00;
    logic        cmd_ready;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rw = 1'b1, cpu_sync = 1'b0, cpu_mlock_n = 1'b1, cpu_vpull_n = 1'b1;
    logic        cpu_clk, cpu_rst_n, cpu_rdy, cpu_irq_n, cpu_nmi_n, cpu_so_n, cpu_be;
    logic        trace_valid;
    logic [7:0]  trace_char;
    logic        trace_ready = 1'b0;

    always #2.5 clk = ~clk;

    bt_step_trace u_bt_step_trace (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .cpu_sync(cpu_sync), .cpu_mlock_n(cpu_mlock_n),
        .cpu_vpull_n(cpu_vpull_n), .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
        .cpu_rdy(cpu_rdy), .cpu_irq_n(cpu_irq_n), .cpu_nmi_n(cpu_nmi_n),
        .cpu_so_n(cpu_so_n), .cpu_be(cpu_be), .trace_valid(trace_valid),
        .trace_char(trace_char), .trace_ready(trace_ready)
    );

    int checks = 0, errors = 0;
    int rises = 0, rises_rst = 0, recs = 0, rdy_cyc = 0;
    int rpos = 0;
    bit stall = 1'b0;
    logic prev_clk = 1'b0;
    logic [15:0] e_addr = '0;
    logic [7:0]  e_data = '0;
    logic        e_rw = 1'b1, e_sync = 1'b0, e_ml = 1'b1, e_vp = 1'b1;
    logic [7:0]  rbuf [14];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hx(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h61 + {4'h0, n} - 8'd10);
    endfunction

    // Expected record character from the bus values the bench drove.
    function automatic logic [7:0] exp_char(input int i);
        case (i)
            0:  return e_rw ? "r" : "W";
            1:  return e_sync ? "S" : "-";
            2:  return e_ml ? "-" : "M";
            3:  return e_vp ? "-" : "V";
            4:  return " ";
            5:  return hx(e_addr[15:12]);
            6:  return hx(e_addr[11:8]);
            7:  return hx(e_addr[7:4]);
            8:  return hx(e_addr[3:0]);
            9:  return " ";
            10: return hx(e_data[7:4]);
            11: return hx(e_data[3:0]);
            12: return 8'h0D;
            default: return 8'h0A;
        endcase
    endfunction

    // Processor model, trace consumer and record checker.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (cpu_clk && !prev_clk) begin
                    rises++;
                    if (!cpu_rst_n) rises_rst++;
                    cpu_addr    = 16'($urandom);
                    cpu_data    = 8'($urandom);
                    cpu_rw      = 1'($urandom);
                    cpu_sync    = 1'($urandom);
                    cpu_mlock_n = 1'($urandom);
                    cpu_vpull_n = 1'($urandom);
                    e_addr = cpu_addr; e_data = cpu_data; e_rw = cpu_rw;
                    e_sync = cpu_sync; e_ml = cpu_mlock_n; e_vp = cpu_vpull_n;
                end
                prev_clk = cpu_clk;
                if (cmd_ready) rdy_cyc++;
                trace_ready = stall ? 1'b0 : ($urandom % 4 != 0);
                if (trace_valid && trace_ready) begin
                    rbuf[rpos] = trace_char;
                    rpos++;
                    if (rpos == 14) begin
                        int bad = -1;
                        rpos = 0;
                        recs++;
                        for (int k = 0; k < 14; k++)
                            if (bad < 0 && rbuf[k] != exp_char(k)) bad = k;
                        chk(bad < 0, "R10 record content", bad < 0 ? 0 : int'(rbuf[bad]),
                            bad < 0 ? 0 : int'(exp_char(bad)));
                    end
                end
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = b;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_rec(input int target, input string req);
        int n = 0;
        while (recs < target && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(recs == target, req, recs, target);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] junk_byte();
        logic [7:0] b;
        do b = 8'($urandom); while (b == "s" || b == "c" || b == "b" || b == "r");
        return b;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int r0, c0, k0, d0;
        void'($urandom(32'd1729));
        idle(5);
        // Reset state.
        chk(cpu_rst_n == 1'b0, "R1 reset asserted", cpu_rst_n, 0);
        chk({cpu_rdy, cpu_irq_n, cpu_nmi_n, cpu_so_n, cpu_be} == 5'b11111,
            "R2 control lines high", int'({cpu_rdy, cpu_irq_n, cpu_nmi_n, cpu_so_n, cpu_be}), 31);
        chk(!trace_valid && !cpu_clk && !cmd_ready, "R3 quiet in reset", trace_valid, 0);
        rst_n = 1'b1;
        // Power-up sequence then first traced cycle in step mode.
        wait_rec(1, "R3 first record");
        chk(rises_rst == 2, "R1 low clock count", rises_rst, 2);
        chk(rises == 10, "R1 high clock count plus bus cycle", rises, 10);
        chk({cpu_rdy, cpu_irq_n, cpu_nmi_n, cpu_so_n, cpu_be} == 5'b11111,
            "R2 control lines after reset", 0, 0);
        idle(30);
        chk(rises == 10 && cmd_ready && !cpu_clk, "R3 halted", rises, 10);

        // Random junk then step, several times.
        for (int it = 0; it < 10; it++) begin
            c0 = rises; k0 = recs;
            send(junk_byte());
            idle(20);
            chk(rises == c0 && recs == k0, "R8 junk ignored in step", rises - c0, 0);
            send("s");
            wait_rec(k0 + 1, "R4 step record");
            idle(10);
            chk(rises == c0 + 1, "R4 one edge per step", rises - c0, 1);
        end

        // Break while stepping has no effect.
        c0 = rises; k0 = recs;
        send("b");
        idle(30);
        chk(rises == c0 && recs == k0 && cmd_ready, "R7 break ignored in step", rises - c0, 0);

        // Back-pressure on the trace stream.
        stall = 1'b1;
        send("s");
        while (!trace_valid) @(negedge clk);
        d0 = int'(trace_char);
        idle(12);
        chk(trace_valid && int'(trace_char) == d0, "R11 stall holds", int'(trace_char), d0);
        stall = 1'b0;
        wait_rec(k0 + 1, "R11 record completes");

        // Free running.
        send("c");
        c0 = rises; k0 = recs; d0 = rdy_cyc;
        idle(300);
        chk(rises - c0 >= 90, "R5 clock runs", rises - c0, 100);
        chk(recs == k0, "R5 no records", recs, k0);
        chk((rdy_cyc - d0) - (rises - c0) <= 1 && (rises - c0) - (rdy_cyc - d0) <= 1,
            "R12 one poll per bus cycle", rdy_cyc - d0, rises - c0);
        send("s"); send("c"); send(junk_byte());
        c0 = rises;
        idle(100);
        chk(recs == k0 && rises - c0 >= 30, "R7 step/cont ignored when free", recs, k0);

        // Reset while free keeps free mode.
        r0 = rises_rst;
        send("r");
        idle(200);
        chk(rises_rst == r0 + 2, "R9 reset in free mode", rises_rst - r0, 2);
        chk(recs == k0, "R9 mode kept free", recs, k0);

        // Break while free returns to stepping.
        send("b");
        wait_rec(k0 + 1, "R6 break traces next cycle");
        c0 = rises;
        idle(40);
        chk(rises == c0 && cmd_ready, "R6 halted after break", rises - c0, 0);

        // Reset while stepping keeps step mode.
        r0 = rises_rst; c0 = rises; k0 = recs;
        send("r");
        wait_rec(k0 + 1, "R9 reset in step mode traced");
        chk(rises_rst == r0 + 2, "R9 R1 low count on command", rises_rst - r0, 2);
        chk(rises == c0 + 10, "R9 R1 total count on command", rises - c0, 10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule